// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Execute Sequencer

This block steps through a byte stream held in a byte-wide program memory, one byte per bus cycle. It addresses the memory through a 16-bit program counter, and that counter always names the next byte to read. The first byte of each instruction is the opcode. The opcode alone decides how many operand bytes the sequencer reads next. After the last operand byte has arrived, the instruction executes in one extra cycle. Instructions run from one to four bytes.

The supported subset works on an 8-bit accumulator:
- load an immediate value;
- add an immediate value;
- clear the accumulator;
- store the accumulator to a page-zero address or to a full 16-bit address;
- stop.

One opcode is an escape prefix. The byte after it is decoded from a second opcode table. Any opcode that is not implemented sets a sticky illegal flag and halts the sequencer.

It is used as the control core of a tiny test engine. Its memory port is synchronous: read data for the address driven in a cycle is taken at the end of that same cycle, and a write is performed at the end of the cycle in which the write strobe is high.

Top module: `seq_fetch_exec`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the sequencer reads address RESET_PC (default 0x0080) with halted and illegal at 0 and no write.
- R2: An instruction of n bytes uses n read cycles at consecutive addresses, then one execute cycle, and the next opcode read follows directly. Two reads in adjacent cycles are always at consecutive addresses.
- R3: Opcode 0xA6 (2 bytes) loads the accumulator with the byte that follows it.
- R4: Opcode 0xAB (2 bytes) adds the following byte to the accumulator, modulo 256.
- R5: Opcode 0xB7 (2 bytes) writes the accumulator during its execute cycle to address 0x00nn, where nn is the following byte.
- R6: Opcode 0x4F (1 byte) sets the accumulator to zero.
- R7: Opcode 0x8E (1 byte) stops execution. From the cycle after its execute cycle, halted is 1 and there is no read and no write, until reset.
- R8: Opcode 0x9E is an escape: the next byte is decoded from the second table. There, 0xD7 stores the accumulator to the 16-bit address in the two bytes after it, high byte first, so the instruction is 4 bytes long.
- R9: Opcode 0xC7 (3 bytes) stores the accumulator to the 16-bit address in the two bytes after it, high byte first.
- R10: An opcode absent from its table sets illegal and halted from the next cycle. This includes 0x9E read from the second table. The instruction never executes, and both flags hold until reset.
- R11: The stream A6 0C AB 17 B7 00 8E leaves 0x23 at address 0x0000 and halts after 11 running cycles.
- R12: A read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 8 | Byte read from memory at mem_addr, taken at the end of a read cycle |
| mem_addr | output | ADDR_W | Address of the current read or write |
| mem_rd | output | 1 | Read strobe for the current cycle |
| mem_wr | output | 1 | Write strobe for the current cycle |
| mem_wdata | output | 8 | Accumulator value written when mem_wr is high |
| halted | output | 1 | Sequencer is stopped |
| illegal | output | 1 | An unimplemented opcode was fetched |

## Verification
Directed programs come first:
- The sample stream tells apart correct operand sequencing from an off-by-one in the operand count.
- A wrapping add separates modulo-256 arithmetic from saturating or wider arithmetic.
- A clear placed between a load and a store separates the clear from a no-op.
- Stores of each length give addresses with distinct high and low bytes, so a byte-order swap shows up as a store to the wrong location.

Illegal bytes follow, on both pages and as a doubled escape, each followed by a store that must never run. These show whether the sequencer really stops or skips ahead.

Random programs mix all five operations, of every length, and sometimes end in an illegal byte. The final memory image, the write count and the running cycle count are each compared with an independent instruction-level model.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int BYTE_W = 8;

  // page-one opcodes
  localparam logic [7:0] OPC_LDI   = 8'hA6;
  localparam logic [7:0] OPC_ADDI  = 8'hAB;
  localparam logic [7:0] OPC_STZP  = 8'hB7;
  localparam logic [7:0] OPC_STEXT = 8'hC7;
  localparam logic [7:0] OPC_CLRA  = 8'h4F;
  localparam logic [7:0] OPC_STOP  = 8'h8E;
  localparam logic [7:0] OPC_ESC   = 8'h9E;
  // page-two opcodes
  localparam logic [7:0] OPC2_STEXT = 8'hD7;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_OPND = 2'd1,
    ST_EXEC = 2'd2,
    ST_HALT = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    OK_LDI   = 3'd0,
    OK_ADDI  = 3'd1,
    OK_STZP  = 3'd2,
    OK_STEXT = 3'd3,
    OK_CLRA  = 3'd4,
    OK_STOP  = 3'd5,
    OK_ESC   = 3'd6,
    OK_BAD   = 3'd7
  } op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic [1:0]  n_opnd;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic page2, input logic [7:0] op);
    op_dec_t d;
    d.kind   = OK_BAD;
    d.n_opnd = 2'd0;
    if (!page2) begin
      case (op)
        OPC_LDI:   begin d.kind = OK_LDI;   d.n_opnd = 2'd1; end
        OPC_ADDI:  begin d.kind = OK_ADDI;  d.n_opnd = 2'd1; end
        OPC_STZP:  begin d.kind = OK_STZP;  d.n_opnd = 2'd1; end
        OPC_STEXT: begin d.kind = OK_STEXT; d.n_opnd = 2'd2; end
        OPC_CLRA:  begin d.kind = OK_CLRA;  d.n_opnd = 2'd0; end
        OPC_STOP:  begin d.kind = OK_STOP;  d.n_opnd = 2'd0; end
        OPC_ESC:   begin d.kind = OK_ESC;   d.n_opnd = 2'd0; end
        default:   begin d.kind = OK_BAD;   d.n_opnd = 2'd0; end
      endcase
    end else begin
      if (op == OPC2_STEXT) begin
        d.kind   = OK_STEXT;
        d.n_opnd = 2'd2;
      end
    end
    return d;
  endfunction

  function automatic logic [BYTE_W-1:0] add_wrap(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [BYTE_W-1:0] acc_next(input op_kind_e kind,
                                                 input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] imm);
    logic [BYTE_W-1:0] r;
    case (kind)
      OK_LDI:  r = imm;
      OK_ADDI: r = add_wrap(acc, imm);
      OK_CLRA: r = '0;
      default: r = acc;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic       page2,
  input  logic [7:0] opcode,
  output op_kind_e   kind,
  output logic [1:0] n_opnd
);
  op_dec_t dec;

  always_comb begin
    dec    = decode_op(page2, opcode);
    kind   = dec.kind;
    n_opnd = dec.n_opnd;
  end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc
);
  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc <= RESET_PC;
    else if (inc) pc <= pc_step(pc);
  end
endmodule

// File: rtl/seq_opnd.sv
module seq_opnd
  import seq_pkg::*;
#(
  parameter int N_BYTES = 2,
  localparam int W = N_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [W-1:0]      opnd
);
  // earlier bytes move up, so the first operand byte ends as the high byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        opnd <= '0;
    else if (clr)      opnd <= '0;
    else if (shift_en) opnd <= {opnd[W-BYTE_W-1:0], byte_in};
  end
endmodule

// File: rtl/seq_acc.sv
module seq_acc
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  op_kind_e          kind,
  input  logic [BYTE_W-1:0] imm,
  output logic [BYTE_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (exec_en) acc <= acc_next(kind, acc, imm);
  end
endmodule

// File: rtl/seq_fetch_exec.sv
module seq_fetch_exec
  import seq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              halted,
  output logic              illegal
);
  localparam int OPND_BYTES = 2;
  localparam int OPND_W     = OPND_BYTES * BYTE_W;
  localparam int ZP_PAD     = ADDR_W - BYTE_W;

  seq_state_e        state_q, state_d;
  logic              page2_q, page2_d;
  op_kind_e          kind_q, kind_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              illegal_q, illegal_d;

  logic [ADDR_W-1:0] pc;
  logic [OPND_W-1:0] opnd;
  logic [BYTE_W-1:0] acc;
  op_kind_e          dec_kind;
  logic [1:0]        dec_n;

  // named events for the checker
  logic ev_fetch_op, ev_fetch_opnd, ev_exec, ev_escape, ev_bad, ev_store;

  function automatic logic [ADDR_W-1:0] zp_addr(input logic [BYTE_W-1:0] lo);
    return {{ZP_PAD{1'b0}}, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] ext_addr(input logic [OPND_W-1:0] o);
    return o[ADDR_W-1:0];
  endfunction

  seq_decode u_dec (
    .page2  (page2_q),
    .opcode (mem_rdata),
    .kind   (dec_kind),
    .n_opnd (dec_n)
  );

  seq_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (mem_rd),
    .pc    (pc)
  );

  seq_opnd #(.N_BYTES(OPND_BYTES)) u_opnd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_fetch_op),
    .shift_en (ev_fetch_opnd),
    .byte_in  (mem_rdata),
    .opnd     (opnd)
  );

  seq_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (ev_exec),
    .kind    (kind_q),
    .imm     (opnd[BYTE_W-1:0]),
    .acc     (acc)
  );

  always_comb begin
    ev_fetch_op   = (state_q == ST_OPC);
    ev_fetch_opnd = (state_q == ST_OPND);
    ev_exec       = (state_q == ST_EXEC);
    ev_escape     = ev_fetch_op && (dec_kind == OK_ESC);
    ev_bad        = ev_fetch_op && (dec_kind == OK_BAD);
    ev_store      = ev_exec && ((kind_q == OK_STZP) || (kind_q == OK_STEXT));
  end

  always_comb begin
    state_d   = state_q;
    page2_d   = page2_q;
    kind_d    = kind_q;
    cnt_d     = cnt_q;
    illegal_d = illegal_q;
    case (state_q)
      ST_OPC: begin
        if (ev_escape) begin
          page2_d = 1'b1;
        end else if (ev_bad) begin
          illegal_d = 1'b1;
          state_d   = ST_HALT;
        end else begin
          kind_d  = dec_kind;
          cnt_d   = dec_n;
          state_d = (dec_n == 2'd0) ? ST_EXEC : ST_OPND;
        end
      end
      ST_OPND: begin
        cnt_d = cnt_q - 2'd1;
        if (cnt_q == 2'd1) state_d = ST_EXEC;
      end
      ST_EXEC: begin
        page2_d = 1'b0;
        state_d = (kind_q == OK_STOP) ? ST_HALT : ST_OPC;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OPC;
      page2_q   <= 1'b0;
      kind_q    <= OK_STOP;
      cnt_q     <= 2'd0;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      page2_q   <= page2_d;
      kind_q    <= kind_d;
      cnt_q     <= cnt_d;
      illegal_q <= illegal_d;
    end
  end

  always_comb begin
    mem_rd    = ev_fetch_op || ev_fetch_opnd;
    mem_wr    = ev_store;
    mem_wdata = acc;
    if (ev_store && (kind_q == OK_STZP))       mem_addr = zp_addr(opnd[BYTE_W-1:0]);
    else if (ev_store && (kind_q == OK_STEXT)) mem_addr = ext_addr(opnd);
    else                                       mem_addr = pc;
    halted  = (state_q == ST_HALT);
    illegal = illegal_q;
  end
endmodule

// File: rtl/seq_fetch_exec_chk.sv
module seq_fetch_exec_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted,
  input logic              illegal,
  input logic              ev_exec,
  input logic              ev_bad
);
  p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  p_illegal_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

  p_illegal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  p_bad_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> (illegal && halted));

  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_exec_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exec && !halted) |=> (mem_rd || halted));
endmodule

bind seq_fetch_exec seq_fetch_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .halted   (halted),
  .illegal  (illegal),
  .ev_exec  (ev_exec),
  .ev_bad   (ev_bad)
);

// File: tb/tb_seq_fetch_exec.sv
module tb_seq_fetch_exec;
  localparam int ADDR_W = 16;
  localparam logic [15:0] RST_PC = 16'h0080;
  localparam int MEM_N = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr, halted, illegal;
  logic [7:0] mem_wdata;

  logic [7:0] mem [0:MEM_N-1];
  logic [7:0] exp_mem [0:MEM_N-1];
  logic [7:0] prog_q[$];
  int wr_count;
  int exp_cyc, exp_wr;
  logic exp_ill;
  int checks = 0, errors = 0;
  int total_cyc = 0;

  always #4 clk = ~clk;

  seq_fetch_exec #(.ADDR_W(ADDR_W), .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .halted(halted), .illegal(illegal)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    total_cyc = total_cyc + 1;
    if (mem_wr) begin
      mem[mem_addr[9:0]] = mem_wdata;
      wr_count = wr_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] b_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0];
  endfunction

  // instruction-level model of the requirements
  task automatic model();
    int i;
    logic [7:0] acc, op;
    bit p2, done;
    int nb;
    logic [15:0] ea;
    i = 0; acc = 8'h00; done = 0;
    exp_cyc = 0; exp_wr = 0; exp_ill = 0;
    while (!done && i < prog_q.size()) begin
      op = prog_q[i]; p2 = 0; nb = 1;
      if (op == 8'h9E) begin p2 = 1; op = prog_q[i+1]; nb = 2; end
      if (!p2 && op == 8'hA6) begin acc = prog_q[i+1]; exp_cyc += 3; i += 2; end
      else if (!p2 && op == 8'hAB) begin acc = b_add(acc, prog_q[i+1]); exp_cyc += 3; i += 2; end
      else if (!p2 && op == 8'hB7) begin
        exp_mem[{2'b00, prog_q[i+1]}] = acc; exp_wr++; exp_cyc += 3; i += 2;
      end
      else if (!p2 && op == 8'hC7) begin
        ea = {prog_q[i+1], prog_q[i+2]};
        exp_mem[ea[9:0]] = acc; exp_wr++; exp_cyc += 4; i += 3;
      end
      else if (!p2 && op == 8'h4F) begin acc = 8'h00; exp_cyc += 2; i += 1; end
      else if (!p2 && op == 8'h8E) begin exp_cyc += 2; done = 1; end
      else if (p2 && op == 8'hD7) begin
        ea = {prog_q[i+2], prog_q[i+3]};
        exp_mem[ea[9:0]] = acc; exp_wr++; exp_cyc += 5; i += 4;
      end
      else begin exp_cyc += nb; exp_ill = 1; done = 1; end
    end
  endtask

  task automatic run(input string req);
    int cyc, seq_bad, both;
    logic prev_rd;
    logic [15:0] prev_addr;
    bit quiet;
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < MEM_N; k++) begin mem[k] = 8'h00; exp_mem[k] = 8'h00; end
    for (int k = 0; k < prog_q.size(); k++) begin
      mem[RST_PC[9:0] + k] = prog_q[k];
      exp_mem[RST_PC[9:0] + k] = prog_q[k];
    end
    model();
    @(negedge clk);
    wr_count = 0;
    // R1: reset state
    chk(mem_addr == RST_PC && !halted && !illegal && !mem_wr, "R1 reset state",
        {halted, illegal, mem_wr, mem_addr}, {3'b000, RST_PC});
    rst_n = 1'b1;
    #1;
    chk(mem_rd && mem_addr == RST_PC && !halted && !illegal, "R1 first fetch",
        mem_addr, RST_PC);
    cyc = 0; seq_bad = 0; both = 0; prev_rd = 0; prev_addr = '0;
    while (!halted && cyc < 500) begin
      if (mem_rd && prev_rd && mem_addr != prev_addr + 16'd1) seq_bad++;
      if (mem_rd && mem_wr) both++;
      prev_rd = mem_rd; prev_addr = mem_addr;
      cyc++;
      @(negedge clk); #1;
    end
    chk(cyc == exp_cyc, {req, " R2 cycle count"}, cyc, exp_cyc);
    chk(seq_bad == 0, "R2 sequential reads", seq_bad, 0);
    chk(both == 0, "R12 read and write together", both, 0);
    chk(illegal == exp_ill, exp_ill ? "R10 illegal flag" : "R7 no illegal on stop",
        illegal, exp_ill);
    quiet = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!halted || mem_rd || mem_wr || illegal != exp_ill) quiet = 0;
    end
    chk(quiet, "R7 halt holds with no access", quiet, 1);
    chk(wr_count == exp_wr, {req, " write count"}, wr_count, exp_wr);
    begin
      int bad_at; bad_at = -1;
      for (int k = 0; k < MEM_N; k++)
        if (bad_at < 0 && mem[k] !== exp_mem[k]) bad_at = k;
      if (bad_at < 0) chk(1, req, 0, 0);
      else chk(0, {req, " memory image"}, mem[bad_at], exp_mem[bad_at]);
    end
  endtask

  function automatic logic [7:0] pick_bad(input bit page2);
    logic [7:0] b;
    do b = 8'($urandom);
    while ((!page2 && (b == 8'hA6 || b == 8'hAB || b == 8'hB7 || b == 8'hC7 ||
                       b == 8'h4F || b == 8'h8E || b == 8'h9E)) ||
           (page2 && b == 8'hD7));
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=hung expected=halt");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R11 sample program, also R3 R4 R5
    prog_q = '{8'hA6, 8'h0C, 8'hAB, 8'h17, 8'hB7, 8'h00, 8'h8E};
    run("R11 sample sum");
    chk(mem[0] == 8'h23, "R11 result at 0x0000", mem[0], 8'h23);
    chk(exp_cyc == 11, "R11 cycle budget", exp_cyc, 11);
    // R4 wrap
    prog_q = '{8'hA6, 8'hF0, 8'hAB, 8'h25, 8'hB7, 8'h20, 8'h8E};
    run("R4 add wraps");
    chk(mem[8'h20] == 8'h15, "R4 wrapped sum", mem[8'h20], 8'h15);
    // R6 clear
    prog_q = '{8'hA6, 8'h55, 8'h4F, 8'hB7, 8'h10, 8'h8E};
    mem[16'h10] = 8'hEE;
    run("R6 clear");
    chk(mem[8'h10] == 8'h00, "R6 cleared then stored", mem[8'h10], 8'h00);
    // R3 load then R5 store
    prog_q = '{8'hA6, 8'h3C, 8'hB7, 8'h7F, 8'h8E};
    run("R3 R5 load and store");
    chk(mem[8'h7F] == 8'h3C, "R5 page-zero store", mem[8'h7F], 8'h3C);
    // R9 three-byte store, high byte first
    prog_q = '{8'hA6, 8'h77, 8'hC7, 8'h03, 8'h01, 8'h8E};
    run("R9 ext store");
    chk(mem[10'h301] == 8'h77, "R9 big-endian address", mem[10'h301], 8'h77);
    // R8 escaped four-byte store
    prog_q = '{8'hA6, 8'h5A, 8'h9E, 8'hD7, 8'h02, 8'h34, 8'h8E};
    run("R8 escaped store");
    chk(mem[10'h234] == 8'h5A, "R8 page-two store", mem[10'h234], 8'h5A);
    // R10 illegal cases, each followed by a store that must not run
    prog_q = '{8'hA6, 8'h11, 8'hFF, 8'hB7, 8'h00, 8'h8E};
    run("R10 illegal page one");
    prog_q = '{8'hA6, 8'h22, 8'h9E, 8'h4F, 8'hB7, 8'h01, 8'h8E};
    run("R10 illegal page two");
    prog_q = '{8'h9E, 8'h9E, 8'hB7, 8'h02, 8'h8E};
    run("R10 doubled escape");
    chk(wr_count == 0, "R10 no execute after illegal", wr_count, 0);
    // random programs
    for (int p = 0; p < 24; p++) begin
      int n;
      logic [15:0] ea;
      prog_q = {};
      n = 1 + ($urandom % 10);
      for (int k = 0; k < n; k++) begin
        case ($urandom % 6)
          0: begin prog_q.push_back(8'hA6); prog_q.push_back(8'($urandom)); end
          1: begin prog_q.push_back(8'hAB); prog_q.push_back(8'($urandom)); end
          2: begin prog_q.push_back(8'hB7); prog_q.push_back(8'($urandom % 128)); end
          3: prog_q.push_back(8'h4F);
          4: begin
            ea = 16'h0200 + 16'($urandom % 512);
            prog_q.push_back(8'hC7); prog_q.push_back(ea[15:8]); prog_q.push_back(ea[7:0]);
          end
          default: begin
            ea = 16'h0200 + 16'($urandom % 512);
            prog_q.push_back(8'h9E); prog_q.push_back(8'hD7);
            prog_q.push_back(ea[15:8]); prog_q.push_back(ea[7:0]);
          end
        endcase
      end
      if (p % 6 == 5) prog_q.push_back(pick_bad(1'b0));
      else if (p % 6 == 4) begin prog_q.push_back(8'h9E); prog_q.push_back(pick_bad(1'b1)); end
      else prog_q.push_back(8'h8E);
      prog_q.push_back(8'hB7); prog_q.push_back(8'h05);
      prog_q.push_back(8'h8E);
      run("R2 R3 R4 R5 R6 R8 R9 random program");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule